// File: doc/BRIEF.md
# Boot Image Record Parser

This block turns a stream of 32-bit boot words into memory writes. The stream is a series of records. Each record opens with two header words: a tag and a destination address. The tag holds a record kind, a target processor number and a word count. The parser compares the target number with its own static processor ID.

A matching copy record stores its payload words at consecutive addresses. A matching fill record writes zeros without taking any words from the stream. Records aimed at another processor are consumed and discarded, and nothing is stored. A final record replaces the 256-word boot region at addresses 0x00 to 0xFF. Its first four words are kept back in registers and written to memory last, so the code at the bottom of the region is replaced only after the rest is in place. One cycle after that last write, a one-cycle start pulse tells the rest of the chip to begin execution.

The stream side is a plain valid/ready pair. The memory side is a single write port with address, data and write enable; the write port has no back-pressure.

Top module: `boot_rec_loader`

## Requirements
- R1: Each record starts with two accepted words. The first is a tag: bits 31:30 give the kind (0 final, 1 copy, 2 fill, 3 reserved), bits 29:27 give the target ID, bits 26:16 are ignored and bits 15:0 give COUNT. The second word is the destination address. For a matching copy record, the next COUNT accepted words are written, in order, to destination, destination+1, and so on.
- R2: A matching fill record writes COUNT zero words from the destination upwards. It accepts no stream words while it does so, and the next accepted word is the tag of the next record.
- R3: A copy or fill record with COUNT 0 performs no write, and the word after its destination is taken as a new tag.
- R4: A copy record whose target ID differs from proc_id has its COUNT payload words accepted and discarded, with no writes.
- R5: A fill record whose target ID differs from proc_id takes no payload words and makes no writes; the word after its destination is the next tag.
- R6: A final record whose target ID differs from proc_id has 256 words accepted and discarded, with no writes, and parsing continues with the next tag.
- R7: A matching final record takes 256 payload words, whatever its COUNT and destination say. Words 0 to 3 are held back. Words 4 to 255 are written to addresses 4 to 255 in order, and the held words are then written to addresses 0 to 3 in order, as the last four writes.
- R8: boot_start is high for exactly one cycle, in the cycle after the write to address 3. After the pulse, in_ready and mem_we stay low until reset.
- R9: A tag of kind 3, whatever its target ID, sets load_err once its destination word has been accepted. load_err then stays high, and in_ready and mem_we stay low, until reset.
- R10: Right after reset, in_ready is high and mem_we, boot_start and load_err are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_id | input | 3 | Static ID of this processor |
| in_valid | input | 1 | Boot word present |
| in_data | input | 32 | Boot word |
| in_ready | output | 1 | Parser takes the word this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W (16) | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| boot_start | output | 1 | One-cycle start pulse after the final load |
| load_err | output | 1 | Sticky reserved-kind error |

## Verification
On every cycle, the assertions check the following. The start pulse lasts a single cycle. It comes right after a write to address 3, and after it the parser accepts no words and makes no writes. The error flag never clears, and while it is set the block stays quiet. Whether the right words reach the right addresses can only be shown by the bench's scenarios. This covers the order of the held-back boot words, how many words a skipped record discards, and that a fill consumes nothing. Each scenario sends a record mix and compares the logged writes with a memory model built from the record contents.

// File: rtl/brl_pkg.sv
package brl_pkg;
    localparam int WORD_W    = 32;
    localparam int KIND_HI   = 31;
    localparam int KIND_LO   = 30;
    localparam int TGT_HI    = 29;
    localparam int TGT_LO    = 27;
    localparam int CNT_HI    = 15;
    localparam int CNT_W     = CNT_HI + 1;
    localparam int TGT_W     = TGT_HI - TGT_LO + 1;

    typedef enum logic [1:0] {
        REC_FINAL = 2'd0,
        REC_COPY  = 2'd1,
        REC_ZERO  = 2'd2,
        REC_RSVD  = 2'd3
    } rec_kind_e;

    typedef enum logic [3:0] {
        S_HDR0    = 4'd0,
        S_HDR1    = 4'd1,
        S_COPY    = 4'd2,
        S_ZERO    = 4'd3,
        S_SKIP    = 4'd4,
        S_FHOLD   = 4'd5,
        S_FBODY   = 4'd6,
        S_FCOMMIT = 4'd7,
        S_LAUNCH  = 4'd8,
        S_DONE    = 4'd9,
        S_HALT    = 4'd10
    } seq_st_e;
endpackage

// File: rtl/brl_tag_decode.sv
module brl_tag_decode
    import brl_pkg::*;
(
    input  logic [KIND_HI-TGT_LO:0] tag_hi,
    input  logic [CNT_W-1:0]        tag_lo,
    output rec_kind_e               kind,
    output logic [TGT_W-1:0]        target,
    output logic [CNT_W-1:0]        count
);
    always_comb begin
        kind   = rec_kind_e'(tag_hi[KIND_HI-TGT_LO -: 2]);
        target = tag_hi[TGT_W-1:0];
        count  = tag_lo;
    end
endmodule

// File: rtl/brl_hold_bank.sv
module brl_hold_bank #(
    parameter int HOLD_WORDS = 4,
    parameter int DATA_W     = 32,
    localparam int IDX_W     = (HOLD_WORDS > 1) ? $clog2(HOLD_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [HOLD_WORDS];
    logic [DATA_W-1:0] slot_d [HOLD_WORDS];

    for (genvar g = 0; g < HOLD_WORDS; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d[g];
            end
        end
    end

    always_comb begin
        rd_data = slot_q[rd_idx];
    end
endmodule

// File: rtl/brl_seq.sv
module brl_seq
    import brl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BOOT_WORDS = 256,
    parameter int HOLD_WORDS = 4,
    localparam int IDX_W     = (HOLD_WORDS > 1) ? $clog2(HOLD_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TGT_W-1:0]  proc_id,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  rec_kind_e         dec_kind,
    input  logic [TGT_W-1:0]  dec_target,
    input  logic [CNT_W-1:0]  dec_count,
    input  logic [WORD_W-1:0] hold_rd_data,
    output logic              in_ready,
    output logic              hold_we,
    output logic [IDX_W-1:0]  hold_idx,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              boot_start,
    output logic              load_err
);
    typedef struct packed {
        seq_st_e             st;
        rec_kind_e           kind;
        logic                id_hit;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   ptr;
        logic [IDX_W-1:0]    idx;
        logic                we;
        logic [ADDR_W-1:0]   waddr;
        logic [WORD_W-1:0]   wdata;
        logic                start;
        logic                err;
    } seq_regs_t;

    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(HOLD_WORDS - 1);
    localparam logic [ADDR_W-1:0] BODY_BASE = ADDR_W'(HOLD_WORDS);
    localparam logic [ADDR_W-1:0] BODY_END  = ADDR_W'(BOOT_WORDS - 1);
    localparam logic [CNT_W-1:0]  BOOT_CNT  = CNT_W'(BOOT_WORDS);

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.we   = 1'b0;
        r_d.start = 1'b0;
        in_ready = 1'b0;
        hold_we  = 1'b0;
        case (r_q.st)
            S_HDR0: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.kind   = dec_kind;
                    r_d.id_hit = (dec_target == proc_id);
                    r_d.cnt    = dec_count;
                    r_d.st     = S_HDR1;
                end
            end
            S_HDR1: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.ptr = in_data[ADDR_W-1:0];
                    r_d.idx = '0;
                    if (r_q.kind == REC_RSVD) begin
                        r_d.err = 1'b1;
                        r_d.st  = S_HALT;
                    end else if (!r_q.id_hit) begin
                        case (r_q.kind)
                            REC_COPY:  r_d.st = (r_q.cnt == '0) ? S_HDR0 : S_SKIP;
                            REC_FINAL: begin
                                r_d.cnt = BOOT_CNT;
                                r_d.st  = S_SKIP;
                            end
                            default:   r_d.st = S_HDR0;
                        endcase
                    end else begin
                        case (r_q.kind)
                            REC_COPY: r_d.st = (r_q.cnt == '0) ? S_HDR0 : S_COPY;
                            REC_ZERO: r_d.st = (r_q.cnt == '0) ? S_HDR0 : S_ZERO;
                            default:  r_d.st = S_FHOLD;
                        endcase
                    end
                end
            end
            S_COPY: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.we    = 1'b1;
                    r_d.waddr = r_q.ptr;
                    r_d.wdata = in_data;
                    r_d.ptr   = r_q.ptr + 1'b1;
                    r_d.cnt   = r_q.cnt - 1'b1;
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.st = S_HDR0;
                    end
                end
            end
            S_ZERO: begin
                r_d.we    = 1'b1;
                r_d.waddr = r_q.ptr;
                r_d.wdata = '0;
                r_d.ptr   = r_q.ptr + 1'b1;
                r_d.cnt   = r_q.cnt - 1'b1;
                if (r_q.cnt == CNT_W'(1)) begin
                    r_d.st = S_HDR0;
                end
            end
            S_SKIP: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.st = S_HDR0;
                    end
                end
            end
            S_FHOLD: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    hold_we = 1'b1;
                    r_d.idx = r_q.idx + 1'b1;
                    if (r_q.idx == LAST_IDX) begin
                        r_d.idx = '0;
                        r_d.ptr = BODY_BASE;
                        r_d.st  = S_FBODY;
                    end
                end
            end
            S_FBODY: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.we    = 1'b1;
                    r_d.waddr = r_q.ptr;
                    r_d.wdata = in_data;
                    r_d.ptr   = r_q.ptr + 1'b1;
                    if (r_q.ptr == BODY_END) begin
                        r_d.st = S_FCOMMIT;
                    end
                end
            end
            S_FCOMMIT: begin
                r_d.we    = 1'b1;
                r_d.waddr = ADDR_W'(r_q.idx);
                r_d.wdata = hold_rd_data;
                r_d.idx   = r_q.idx + 1'b1;
                if (r_q.idx == LAST_IDX) begin
                    r_d.st = S_LAUNCH;
                end
            end
            S_LAUNCH: begin
                r_d.start = 1'b1;
                r_d.st    = S_DONE;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_HDR0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        hold_idx   = r_q.idx;
        mem_we     = r_q.we;
        mem_addr   = r_q.waddr;
        mem_wdata  = r_q.wdata;
        boot_start = r_q.start;
        load_err   = r_q.err;
    end
endmodule

// File: rtl/boot_rec_loader.sv
module boot_rec_loader
    import brl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BOOT_WORDS = 256,
    parameter int HOLD_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        proc_id,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              boot_start,
    output logic              load_err
);
    localparam int IDX_W = (HOLD_WORDS > 1) ? $clog2(HOLD_WORDS) : 1;

    rec_kind_e          dec_kind;
    logic [TGT_W-1:0]   dec_target;
    logic [CNT_W-1:0]   dec_count;
    logic               hold_we;
    logic [IDX_W-1:0]   hold_idx;
    logic [WORD_W-1:0]  hold_rd_data;

    brl_tag_decode u_dec (
        .tag_hi (in_data[KIND_HI:TGT_LO]),
        .tag_lo (in_data[CNT_HI:0]),
        .kind   (dec_kind),
        .target (dec_target),
        .count  (dec_count)
    );

    brl_hold_bank #(
        .HOLD_WORDS (HOLD_WORDS),
        .DATA_W     (WORD_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hold_we),
        .wr_idx  (hold_idx),
        .wr_data (in_data),
        .rd_idx  (hold_idx),
        .rd_data (hold_rd_data)
    );

    brl_seq #(
        .ADDR_W     (ADDR_W),
        .BOOT_WORDS (BOOT_WORDS),
        .HOLD_WORDS (HOLD_WORDS)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .proc_id      (proc_id),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .dec_kind     (dec_kind),
        .dec_target   (dec_target),
        .dec_count    (dec_count),
        .hold_rd_data (hold_rd_data),
        .in_ready     (in_ready),
        .hold_we      (hold_we),
        .hold_idx     (hold_idx),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .boot_start   (boot_start),
        .load_err     (load_err)
    );
endmodule

// File: rtl/brl_checks.sv
module brl_checks #(
    parameter int ADDR_W     = 16,
    parameter int HOLD_WORDS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              boot_start,
    input logic              load_err
);
    // R8
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_start |=> !boot_start);

    // R8
    start_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_start |-> ($past(mem_we) && ($past(mem_addr) == ADDR_W'(HOLD_WORDS - 1))));

    // R8
    start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_start |=> (!in_ready && !mem_we));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |=> load_err);

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> (!in_ready && !mem_we && !boot_start));
endmodule

bind boot_rec_loader brl_checks #(
    .ADDR_W     (ADDR_W),
    .HOLD_WORDS (HOLD_WORDS)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .boot_start (boot_start),
    .load_err   (load_err)
);

// File: tb/boot_rec_loader_bench.sv
module boot_rec_loader_bench;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  proc_id = 3'd5;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        boot_start;
    logic        load_err;

    int checks = 0;
    int bad = 0;

    logic [31:0] bmem [0:1023];
    logic [15:0] log_addr [0:511];
    logic [31:0] log_data [0:511];
    int wcount = 0;
    int start_seen = 0;
    int wcnt_at_start = -1;
    logic log_clear = 1'b0;

    boot_rec_loader u_boot_rec_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .proc_id    (proc_id),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .boot_start (boot_start),
        .load_err   (load_err)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (log_clear) begin
            wcount = 0;
            start_seen = 0;
            wcnt_at_start = -1;
            for (int i = 0; i < 1024; i++) bmem[i] = SENT;
        end else begin
            if (boot_start) begin
                start_seen++;
                wcnt_at_start = wcount;
            end
            if (mem_we) begin
                if (wcount < 512) begin
                    log_addr[wcount] = mem_addr;
                    log_data[wcount] = mem_wdata;
                end
                wcount++;
                if (mem_addr < 16'd1024) bmem[mem_addr[9:0]] = mem_wdata;
            end
        end
    end

    initial begin
        #1_500_000;
        checks++;
        bad++;
        $display("FAIL watchdog: run did not complete (actual=hung expected=finished)");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        log_clear = 1'b1;
        idle(3);
        log_clear = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input logic [31:0] w);
        bit taken;
        in_valid = 1'b1;
        in_data = w;
        taken = 1'b0;
        while (!taken) begin
            taken = in_ready;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] tag(input int kind, input int id, input int cnt);
        return {kind[1:0], id[2:0], 11'h5A5, cnt[15:0]};
    endfunction

    task automatic t_reset();
        do_reset();
        chk(in_ready === 1'b1, "R10 in_ready", {31'd0, in_ready}, 32'd1);
        chk(mem_we === 1'b0 && boot_start === 1'b0 && load_err === 1'b0, "R10 outputs low",
            {29'd0, mem_we, boot_start, load_err}, 32'd0);
    endtask

    task automatic t_records();
        do_reset();
        // R1 copy 3 words to 0x100
        send(tag(1, 5, 3)); send(32'h100);
        send(32'hA0A0_0001); send(32'hA0A0_0002); send(32'hA0A0_0003);
        // R2 fill 4 zeros at 0x200
        send(tag(2, 5, 4)); send(32'h200);
        // R3 zero-count copy and fill
        send(tag(1, 5, 0)); send(32'h300);
        send(tag(2, 5, 0)); send(32'h310);
        // R4 foreign copy with 2 payload words
        send(tag(1, 2, 2)); send(32'h140);
        send(32'h1111_1111); send(32'h2222_2222);
        // R5 foreign fill, no payload
        send(tag(2, 6, 5)); send(32'h180);
        // follow-up copy proves the next word was a tag
        send(tag(1, 5, 1)); send(32'h110);
        send(32'hD00D_0004);
        idle(6);
        chk(bmem[10'h100] == 32'hA0A0_0001 && bmem[10'h101] == 32'hA0A0_0002 &&
            bmem[10'h102] == 32'hA0A0_0003, "R1 copy data", bmem[10'h102], 32'hA0A0_0003);
        chk(bmem[10'h103] == SENT, "R1 copy bound", bmem[10'h103], SENT);
        chk(log_addr[0] == 16'h100 && log_addr[2] == 16'h102, "R1 copy order",
            {16'd0, log_addr[2]}, 32'h102);
        chk(bmem[10'h200] == 0 && bmem[10'h203] == 0 && bmem[10'h204] == SENT, "R2 fill",
            bmem[10'h203], 32'd0);
        chk(bmem[10'h300] == SENT && bmem[10'h310] == SENT, "R3 zero count", bmem[10'h300], SENT);
        chk(bmem[10'h140] == SENT && bmem[10'h141] == SENT, "R4 skip copy", bmem[10'h140], SENT);
        chk(bmem[10'h180] == SENT && bmem[10'h184] == SENT, "R5 skip fill", bmem[10'h180], SENT);
        chk(bmem[10'h110] == 32'hD00D_0004, "R5 next word is tag", bmem[10'h110], 32'hD00D_0004);
        chk(wcount == 8, "R4 write total", wcount, 32'd8);
    endtask

    task automatic t_final();
        bit order_ok;
        do_reset();
        proc_id = 3'd3;
        // R6 foreign final: 256 words discarded
        send(tag(0, 1, 7)); send(32'h0);
        for (int i = 0; i < 256; i++) send(32'hEE00_0000 + i);
        chk(wcount == 0, "R6 skip final no writes", wcount, 32'd0);
        // R7 matching final, odd count and destination ignored
        send(tag(0, 3, 9)); send(32'h77);
        for (int i = 0; i < 256; i++) send(32'h1000_0000 + i);
        for (int i = 0; i < 20 && start_seen == 0; i++) @(negedge clk);
        idle(8);
        chk(wcount == 256, "R7 write total", wcount, 32'd256);
        order_ok = 1'b1;
        for (int i = 0; i < 252; i++) begin
            if (log_addr[i] != 16'(i + 4) || log_data[i] != 32'h1000_0000 + 32'(i + 4))
                order_ok = 1'b0;
        end
        chk(order_ok, "R7 body order", {16'd0, log_addr[0]}, 32'd4);
        order_ok = 1'b1;
        for (int k = 0; k < 4; k++) begin
            if (log_addr[252 + k] != 16'(k) || log_data[252 + k] != 32'h1000_0000 + 32'(k))
                order_ok = 1'b0;
        end
        chk(order_ok, "R7 held words last", log_data[255], 32'h1000_0003);
        chk(bmem[0] == 32'h1000_0000 && bmem[255] == 32'h1000_00FF, "R7 region", bmem[255],
            32'h1000_00FF);
        chk(start_seen == 1, "R8 single pulse", start_seen, 32'd1);
        chk(wcnt_at_start == 256, "R8 pulse after last write", wcnt_at_start, 32'd256);
        chk(in_ready === 1'b0 && mem_we === 1'b0, "R8 quiet after start",
            {30'd0, in_ready, mem_we}, 32'd0);
        proc_id = 3'd5;
    endtask

    task automatic t_error();
        do_reset();
        send(tag(3, 2, 4)); send(32'h40);
        idle(2);
        chk(load_err === 1'b1, "R9 error set", {31'd0, load_err}, 32'd1);
        chk(in_ready === 1'b0, "R9 halted", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b1;
        in_data = tag(1, 5, 1);
        idle(10);
        in_valid = 1'b0;
        chk(load_err === 1'b1 && wcount == 0, "R9 sticky no writes", wcount, 32'd0);
    endtask

    initial begin
        t_reset();
        t_records();
        t_final();
        t_error();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule